// File: doc/BRIEF.md
# Slot Hotplug Event Tracker with Eject Request

This block records insertion and removal events for a bank of up to 32 expansion slots and shows them to software through a small window of 32-bit I/O words. A platform agent reports each event as a strobe with a slot number, an insert/remove flag and a flag that marks devices present at power-on. Each reportable event replaces all earlier history. The two slot bitmaps are cleared, the bit for the new event's slot is set in the "arrived" or "departed" map, and a one-cycle pulse goes out to set the hotplug status bit of the general-purpose event bank.

Software asks for a device to be removed by writing a word to the eject port. The lowest set bit of that word selects the slot. The block then sends a one-cycle eject request with that slot number to the logic that detaches the device. The eject port always reads as zero.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, both bitmaps read zero and neither gpe_set nor eject_valid is high.
- R2: An insert event flagged as power-on present (evt_add=1, evt_coldplug=1) leaves both bitmaps unchanged and raises no gpe_set pulse.
- R3: Any other insert event clears both bitmaps and then sets bit evt_slot of the arrived map, visible from the cycle after the strobe.
- R4: Any remove event (evt_add=0), with or without the power-on flag, clears both bitmaps and then sets bit evt_slot of the departed map, visible from the cycle after the strobe.
- R5: Every event covered by R3 or R4 makes gpe_set high for exactly the one cycle after the strobe. gpe_set is never high at any other time.
- R6: With io_addr[1:0]=0, a read of byte offset 0 returns the arrived map, offset 4 the departed map, and offsets 8 and 12 return zero. Any offset with io_addr[1:0] nonzero returns zero.
- R7: A write to byte offset 8 with a nonzero value gives eject_valid high for the one cycle after the write, and eject_slot equals the index of the lowest set bit of the written value.
- R8: A write of zero to offset 8 produces no eject request.
- R9: Writes to offsets 0, 4 and 12, and any misaligned write, change neither bitmap and produce no eject request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Hotplug event strobe, one cycle per event |
| evt_slot | input | 5 | Slot number of the event |
| evt_add | input | 1 | 1 = insert, 0 = remove |
| evt_coldplug | input | 1 | Event describes a device present at power-on |
| io_addr | input | 4 | Byte offset within the register window |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for io_addr (combinational) |
| gpe_set | output | 1 | One-cycle pulse that sets the hotplug event status bit |
| eject_valid | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot number to eject, meaningful while eject_valid is high |

## Verification
On every cycle the assertions check that a silent power-on insert leaves the maps and gpe_set alone, that each reportable event leaves exactly one bit set in the correct map, that gpe_set only follows a reportable event, and that every eject request names the lowest set bit of the word that was just written, with zero writes producing no request. Only the bench's scenarios show the read map over the whole window, the full data path from event to read word, and the effect of back-to-back events and of writes to read-only offsets. The behavioural model covers these and is compared with the outputs every cycle.

// File: rtl/hp_pkg.sv
package hp_pkg;

   // Word windows inside the register block, selected by io_addr[3:2]
   typedef enum logic [1:0] {
      WIN_ARRIVED  = 2'd0,
      WIN_DEPARTED = 2'd1,
      WIN_EJECT    = 2'd2,
      WIN_SPARE    = 2'd3
   } hp_win_e;

   // Decoded access: which window, and whether the offset is word aligned
   typedef struct packed {
      logic    aligned;
      hp_win_e win;
   } hp_sel_t;

   function automatic hp_sel_t hp_decode(input logic [3:0] addr);
      hp_sel_t s;
      s.aligned = (addr[1:0] == 2'b00);
      s.win     = hp_win_e'(addr[3:2]);
      return s;
   endfunction

endpackage

// File: rtl/hp_slot_track.sv
module hp_slot_track #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic [SLOT_W-1:0]    evt_slot,
   input  logic                 evt_add,
   input  logic                 evt_coldplug,
   output logic [NUM_SLOTS-1:0] up_map,
   output logic [NUM_SLOTS-1:0] down_map,
   output logic                 gpe_set
);

   logic silent;
   logic take;

   // Power-on present inserts are not reported
   assign silent = evt_add & evt_coldplug;
   assign take   = evt_valid & ~silent;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic hit;
      assign hit = (evt_slot == SLOT_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_map[i]   <= 1'b0;
            down_map[i] <= 1'b0;
         end else if (take) begin
            // every reported event wipes history, then marks one slot
            up_map[i]   <= hit & evt_add;
            down_map[i] <= hit & ~evt_add;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gpe_set <= 1'b0;
      else        gpe_set <= take;
   end

endmodule

// File: rtl/hp_eject_enc.sv
module hp_eject_enc #(
   parameter int NUM_SLOTS = 32,
   parameter int SLOT_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_eject,
   input  logic [NUM_SLOTS-1:0] req_bits,
   output logic                 eject_valid,
   output logic [SLOT_W-1:0]    eject_slot
);

   logic [SLOT_W-1:0] low_idx;
   logic              any_bit;

   // Lowest set bit wins: scan downward so the last hit is the smallest index
   always_comb begin
      low_idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (req_bits[i]) low_idx = SLOT_W'(i);
      end
   end

   assign any_bit = |req_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eject_valid <= 1'b0;
         eject_slot  <= '0;
      end else begin
         eject_valid <= wr_eject & any_bit;
         if (wr_eject & any_bit) eject_slot <= low_idx;
      end
   end

endmodule

// File: rtl/hp_read_mux.sv
module hp_read_mux
   import hp_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int DATA_W    = 32
) (
   input  hp_sel_t              sel,
   input  logic [NUM_SLOTS-1:0] up_map,
   input  logic [NUM_SLOTS-1:0] down_map,
   output logic [DATA_W-1:0]    rdata
);

   always_comb begin
      rdata = '0;
      if (sel.aligned) begin
         unique case (sel.win)
            WIN_ARRIVED:  rdata[NUM_SLOTS-1:0] = up_map;
            WIN_DEPARTED: rdata[NUM_SLOTS-1:0] = down_map;
            WIN_EJECT:    rdata = '0;
            WIN_SPARE:    rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
   import hp_pkg::*;
#(
   parameter  int NUM_SLOTS = 32,
   parameter  int DATA_W    = 32,
   parameter  int ADDR_W    = 4,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [SLOT_W-1:0] evt_slot,
   input  logic              evt_add,
   input  logic              evt_coldplug,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              gpe_set,
   output logic              eject_valid,
   output logic [SLOT_W-1:0] eject_slot
);

   // Elaboration-time parameter checks
   if (NUM_SLOTS < 2 || NUM_SLOTS > DATA_W) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 2..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic [NUM_SLOTS-1:0] up_map;
   logic [NUM_SLOTS-1:0] down_map;
   hp_sel_t              sel;
   logic                 wr_eject;

   // The window decodes only when address bits above the 16-byte window are zero
   if (ADDR_W > 4) begin : g_wide_addr
      logic in_window;
      assign in_window   = (io_addr[ADDR_W-1:4] == '0);
      assign sel.win     = hp_win_e'(io_addr[3:2]);
      assign sel.aligned = in_window & (io_addr[1:0] == 2'b00);
   end else begin : g_narrow_addr
      assign sel = hp_decode(io_addr[3:0]);
   end

   assign wr_eject = io_wr & sel.aligned & (sel.win == WIN_EJECT);

   hp_slot_track #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_valid    (evt_valid),
      .evt_slot     (evt_slot),
      .evt_add      (evt_add),
      .evt_coldplug (evt_coldplug),
      .up_map       (up_map),
      .down_map     (down_map),
      .gpe_set      (gpe_set)
   );

   hp_eject_enc #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_eject (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_eject    (wr_eject),
      .req_bits    (io_wdata[NUM_SLOTS-1:0]),
      .eject_valid (eject_valid),
      .eject_slot  (eject_slot)
   );

   hp_read_mux #(
      .NUM_SLOTS (NUM_SLOTS),
      .DATA_W    (DATA_W)
   ) u_rmux (
      .sel      (sel),
      .up_map   (up_map),
      .down_map (down_map),
      .rdata    (io_rdata)
   );

endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
   parameter  int NUM_SLOTS = 32,
   parameter  int DATA_W    = 32,
   parameter  int ADDR_W    = 4,
   localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 evt_valid,
   input logic [SLOT_W-1:0]    evt_slot,
   input logic                 evt_add,
   input logic                 evt_coldplug,
   input logic [ADDR_W-1:0]    io_addr,
   input logic                 io_wr,
   input logic [DATA_W-1:0]    io_wdata,
   input logic [DATA_W-1:0]    io_rdata,
   input logic                 gpe_set,
   input logic                 eject_valid,
   input logic [SLOT_W-1:0]    eject_slot,
   input logic [NUM_SLOTS-1:0] up_map,
   input logic [NUM_SLOTS-1:0] down_map
);

   logic eject_wr;
   logic reported;
   logic [NUM_SLOTS-1:0] last_req;

   assign eject_wr = io_wr && (io_addr == ADDR_W'(8));
   assign reported = evt_valid && !(evt_add && evt_coldplug);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        last_req <= '0;
      else if (eject_wr) last_req <= io_wdata[NUM_SLOTS-1:0];
   end

   // R2
   coldplug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_add && evt_coldplug) |=>
         (!gpe_set && $stable(up_map) && $stable(down_map)));

   // R3
   add_marks_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_add && !evt_coldplug) |=>
         (up_map == (NUM_SLOTS'(1) << $past(evt_slot)) && down_map == '0));

   // R4
   remove_marks_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_add) |=>
         (down_map == (NUM_SLOTS'(1) << $past(evt_slot)) && up_map == '0));

   // R5
   gpe_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gpe_set |-> $past(reported));

   // R5
   gpe_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reported |=> gpe_set);

   // R6
   eject_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == ADDR_W'(8)) |-> (io_rdata == '0));

   // R7
   eject_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eject_valid |->
         (last_req[eject_slot] &&
          ((last_req & ((NUM_SLOTS'(1) << eject_slot) - NUM_SLOTS'(1))) == '0)));

   // R7
   eject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eject_wr && io_wdata[NUM_SLOTS-1:0] != '0) |=> eject_valid);

   // R8
   eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eject_wr && io_wdata[NUM_SLOTS-1:0] == '0) |=> !eject_valid);

endmodule

bind slot_hotplug_ctrl hp_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/sim_slot_hotplug_ctrl.sv
`timescale 1ns/1ps
module sim_slot_hotplug_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [4:0]  evt_slot = '0;
   logic        evt_add = 1'b0;
   logic        evt_coldplug = 1'b0;
   logic [3:0]  io_addr = '0;
   logic        io_wr = 1'b0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        gpe_set;
   logic        eject_valid;
   logic [4:0]  eject_slot;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   logic [31:0] m_up = '0, m_down = '0;
   bit          m_gpe = 0, m_ejv = 0;
   int          m_ejslot = 0;

   always #5 clk = ~clk;

   slot_hotplug_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_slot(evt_slot), .evt_add(evt_add),
      .evt_coldplug(evt_coldplug),
      .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .gpe_set(gpe_set), .eject_valid(eject_valid), .eject_slot(eject_slot)
   );

   // model advances on each rising edge from the inputs held since the last one
   always @(posedge clk) begin
      if (!rst_n) begin
         m_up = 0; m_down = 0; m_gpe = 0; m_ejv = 0;
      end else begin
         m_gpe = 0;
         m_ejv = 0;
         if (evt_valid && !(evt_add && evt_coldplug)) begin
            m_up = 0; m_down = 0;
            if (evt_add) m_up[evt_slot] = 1'b1;
            else         m_down[evt_slot] = 1'b1;
            m_gpe = 1;
         end
         if (io_wr && io_addr == 4'd8 && io_wdata != 0) begin
            m_ejv = 1;
            for (int b = 31; b >= 0; b--) if (io_wdata[b]) m_ejslot = b;
         end
      end
   end

   function automatic logic [31:0] exp_rdata(input logic [3:0] a);
      case (a)
         4'd0:    return m_up;
         4'd4:    return m_down;
         default: return 32'h0;
      endcase
   endfunction

   // compare away from the rising edge
   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (io_rdata !== exp_rdata(io_addr)) begin
            errors++;
            $display("FAIL %s R6 rdata@%0d act %h exp %h", cur_req, io_addr, io_rdata, exp_rdata(io_addr));
         end
         checks++;
         if (gpe_set !== m_gpe) begin
            errors++;
            $display("FAIL %s R5 gpe_set act %b exp %b", cur_req, gpe_set, m_gpe);
         end
         checks++;
         if (eject_valid !== m_ejv || (m_ejv && eject_slot !== 5'(m_ejslot))) begin
            errors++;
            $display("FAIL %s R7 eject act %b/%0d exp %b/%0d", cur_req, eject_valid, eject_slot, m_ejv, m_ejslot);
         end
      end
   end

   task automatic idle();
      @(posedge clk); #1;
      evt_valid = 0; io_wr = 0;
   endtask

   task automatic ev(input int slot, input bit add, input bit cold);
      @(posedge clk); #1;
      evt_valid = 1; evt_slot = 5'(slot); evt_add = add; evt_coldplug = cold; io_wr = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      evt_valid = 0; io_wr = 1; io_addr = a; io_wdata = d;
   endtask

   task automatic look(input logic [3:0] a);
      @(posedge clk); #1;
      evt_valid = 0; io_wr = 0; io_addr = a;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      look(4'd0); look(4'd4);

      // R3: hot insert
      cur_req = "R3";
      ev(3, 1, 0); look(4'd0); look(4'd4);
      ev(0, 1, 0); look(4'd0);

      // R4: removes, including power-on flagged remove
      cur_req = "R4";
      ev(31, 0, 0); look(4'd0); look(4'd4);
      ev(7, 0, 1); look(4'd4); look(4'd0);

      // R2: power-on insert is silent
      cur_req = "R2";
      ev(5, 1, 1); look(4'd4); look(4'd0);

      // R5: back-to-back events pulse on each
      cur_req = "R5";
      ev(10, 1, 0); ev(11, 0, 0); ev(12, 1, 0); look(4'd0); look(4'd4);

      // R6: window reads incl. eject and misaligned offsets
      cur_req = "R6";
      look(4'd8); look(4'd12); look(4'd1); look(4'd5); look(4'd2);

      // R7: eject encodes lowest set bit
      cur_req = "R7";
      wr(4'd8, 32'h0000_0008); idle();
      wr(4'd8, 32'h8000_0000); idle();
      wr(4'd8, 32'hFFFF_FFFF); wr(4'd8, 32'h0000_00A0); idle();

      // R8: zero write does nothing
      cur_req = "R8";
      wr(4'd8, 32'h0); idle();

      // R9: writes elsewhere are ignored
      cur_req = "R9";
      wr(4'd0, 32'hFFFF_FFFF); wr(4'd4, 32'h1234_5678); wr(4'd12, 32'h1);
      wr(4'd9, 32'h1); look(4'd0); look(4'd4);

      // mixed traffic
      cur_req = "R3";
      for (int n = 0; n < 400; n++) begin
         @(posedge clk); #1;
         evt_valid    = ($urandom % 3) == 0;
         evt_slot     = 5'($urandom);
         evt_add      = $urandom % 2;
         evt_coldplug = ($urandom % 4) == 0;
         io_wr        = ($urandom % 3) == 0;
         io_addr      = 4'($urandom);
         io_wdata     = ($urandom % 4 == 0) ? 32'h0 : ($urandom << ($urandom % 32));
      end
      idle(); idle();
      @(negedge clk);
      finish_run();
   end

endmodule